// File: doc/BRIEF.md
# VBUS Presence Status Logic

This block watches the two comparator outputs of a USB VBUS pad and produces a registered VBUS presence bit together with a sticky transition flag. One comparator reports a valid session, meaning VBUS is at or above roughly 1.4 V. The other reports fully valid VBUS, meaning VBUS is at or above roughly 4.4 V. Both comparator outputs arrive asynchronously and are resynchronised before use.

A mode input selects how the presence bit is derived. In device mode the bit simply tracks the low threshold. In host mode it uses hysteresis: the high threshold sets it and only a loss of the low threshold clears it. Any change of the bit, in either direction, sets the transition flag. Software-style one-cycle pulses can set or clear the flag, and an enable mask gates it onto the interrupt output. The presence logic keeps working whatever the controller enable is.

The block also keeps a registered pad state. The pad is Active only while the controller is enabled and not detached, and it is Idle otherwise.

Top module: `vbus_presence_monitor`

## Requirements
- R1: While rst_n is low, vbus_present, vbus_chg_flag, irq and pad_active are all 0.
- R2: With host_mode = 0 (device), vbus_present equals the synchronised sess_vld_async, SYNC_STAGES+1 clock edges after the input changes (3 edges at the default).
- R3: With host_mode = 1, vbus_present goes from 0 to 1 only when the synchronised full_vld_async is 1. A session-valid level alone never sets it.
- R4: With host_mode = 1, once vbus_present is 1 it stays 1 while the synchronised sess_vld_async is 1, even if full_vld_async drops. It clears to 0 when the synchronised sess_vld_async goes to 0 and full_vld_async is 0.
- R5: vbus_chg_flag becomes 1 on the same clock edge at which vbus_present changes, for both rising and falling changes.
- R6: vbus_chg_flag is sticky. A one-cycle irq_clr pulse clears it. A one-cycle irq_set pulse sets it. If irq_set and irq_clr coincide, set wins. If a change of vbus_present and irq_clr coincide, the flag stays 1.
- R7: irq is 1 exactly when vbus_chg_flag is 1 and irq_en is 1.
- R8: vbus_present and the transition flag behave the same whether ctrl_en is 0 or 1 and whatever detach_req is.
- R9: pad_active (1 = Active, 0 = Idle) is 1 one clock edge after ctrl_en = 1 with detach_req = 0 is applied. For the other three combinations of ctrl_en and detach_req it is 0 one edge later.
- R10: A switch of host_mode from 1 to 0 re-evaluates vbus_present against the synchronised session level alone on the next clock edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| sess_vld_async | input | 1 | Asynchronous low-threshold (session valid) comparator output |
| full_vld_async | input | 1 | Asynchronous high-threshold (VBUS fully valid) comparator output |
| host_mode | input | 1 | 1 = host behaviour (hysteresis), 0 = device behaviour |
| ctrl_en | input | 1 | Controller enable |
| detach_req | input | 1 | Detach request; forces the pad to Idle |
| irq_en | input | 1 | Interrupt enable mask for the transition flag |
| irq_set | input | 1 | One-cycle pulse that sets the transition flag |
| irq_clr | input | 1 | One-cycle pulse that clears the transition flag |
| vbus_present | output | 1 | Registered VBUS presence status |
| vbus_chg_flag | output | 1 | Sticky VBUS transition flag |
| irq | output | 1 | Transition flag gated by irq_en |
| pad_active | output | 1 | Registered pad state, 1 = Active |

## Verification
A comparator change driven on a falling edge passes the two synchroniser flops and then the status register. The bench therefore samples vbus_present and vbus_chg_flag on the third falling edge after the drive, when both results are due together. The pad state and a host-to-device mode switch act through one register, so they are sampled one falling edge after the drive, and irq is combinational and is read in the same half cycle as the flag or mask it depends on. For the collision of a transition with a clear pulse, the bench places the clear in the cycle that ends with the third edge, so both reach the flag register on the same edge.

// File: rtl/vbus_presence_monitor.sv
module vbus_presence_monitor #(
  parameter int SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic sess_vld_async,
  input  logic full_vld_async,
  input  logic host_mode,
  input  logic ctrl_en,
  input  logic detach_req,
  input  logic irq_en,
  input  logic irq_set,
  input  logic irq_clr,
  output logic vbus_present,
  output logic vbus_chg_flag,
  output logic irq,
  output logic pad_active
);

  logic [SYNC_STAGES-1:0] sess_sh;
  logic [SYNC_STAGES-1:0] full_sh;
  logic sess_s;
  logic full_s;
  logic vbus_nxt;
  logic vbus_chg;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sess_sh <= '0;
      full_sh <= '0;
    end else begin
      sess_sh <= {sess_sh[SYNC_STAGES-2:0], sess_vld_async};
      full_sh <= {full_sh[SYNC_STAGES-2:0], full_vld_async};
    end
  end

  assign sess_s = sess_sh[SYNC_STAGES-1];
  assign full_s = full_sh[SYNC_STAGES-1];

  always_comb begin
    if (!host_mode)   vbus_nxt = sess_s;
    else if (full_s)  vbus_nxt = 1'b1;
    else if (!sess_s) vbus_nxt = 1'b0;
    else              vbus_nxt = vbus_present;
  end

  assign vbus_chg = vbus_nxt ^ vbus_present;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      vbus_present  <= 1'b0;
      vbus_chg_flag <= 1'b0;
      pad_active    <= 1'b0;
    end else begin
      vbus_present <= vbus_nxt;
      if (vbus_chg || irq_set) vbus_chg_flag <= 1'b1;
      else if (irq_clr)        vbus_chg_flag <= 1'b0;
      pad_active <= ctrl_en && !detach_req;
    end
  end

  assign irq = vbus_chg_flag && irq_en;

endmodule

// File: rtl/vbus_presence_checker.sv
module vbus_presence_checker (
  input logic clk,
  input logic rst_n,
  input logic host_mode,
  input logic ctrl_en,
  input logic detach_req,
  input logic irq_set,
  input logic irq_clr,
  input logic sess_s,
  input logic full_s,
  input logic vbus_present,
  input logic vbus_chg_flag,
  input logic pad_active
);

  // R2
  a_r2_device_follow: assert property (@(posedge clk) disable iff (!rst_n)
    !host_mode |=> vbus_present == $past(sess_s));

  // R3
  a_r3_host_no_low_set: assert property (@(posedge clk) disable iff (!rst_n)
    (host_mode && !vbus_present && !full_s) |=> !vbus_present);

  // R4
  a_r4_host_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (host_mode && vbus_present && sess_s) |=> vbus_present);

  // R5
  a_r5_flag_on_change: assert property (@(posedge clk) disable iff (!rst_n)
    (vbus_present != $past(vbus_present)) |-> vbus_chg_flag);

  // R6
  a_r6_clear_works: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(irq_clr) && !$past(irq_set) && vbus_present == $past(vbus_present)) |-> !vbus_chg_flag);

  // R9
  a_r9_pad_idle: assert property (@(posedge clk) disable iff (!rst_n)
    (!ctrl_en || detach_req) |=> !pad_active);

endmodule

bind vbus_presence_monitor vbus_presence_checker u_chk (
  .clk(clk), .rst_n(rst_n), .host_mode(host_mode), .ctrl_en(ctrl_en),
  .detach_req(detach_req), .irq_set(irq_set), .irq_clr(irq_clr),
  .sess_s(sess_s), .full_s(full_s), .vbus_present(vbus_present),
  .vbus_chg_flag(vbus_chg_flag), .pad_active(pad_active)
);

// File: tb/tb_vbus_presence_monitor.sv
`timescale 1ns/1ps
module tb_vbus_presence_monitor;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic sess = 1'b0, full = 1'b0, host = 1'b0;
  logic en = 1'b0, det = 1'b0, ien = 1'b0, iset = 1'b0, iclr = 1'b0;
  logic vbus, flag, irq, pad;

  int checks = 0;
  int fails = 0;
  int raised = 0;
  bit done = 1'b0;

  always #5 clk = ~clk;

  vbus_presence_monitor dut (
    .clk(clk), .rst_n(rst_n), .sess_vld_async(sess), .full_vld_async(full),
    .host_mode(host), .ctrl_en(en), .detach_req(det), .irq_en(ien),
    .irq_set(iset), .irq_clr(iclr), .vbus_present(vbus),
    .vbus_chg_flag(flag), .irq(irq), .pad_active(pad)
  );

  // {host, sess, full, expected vbus, expected flag}
  localparam logic [4:0] VEC [12] = '{
    5'b0_00_00, 5'b0_10_11, 5'b0_11_10, 5'b0_10_10, 5'b0_00_01,
    5'b1_10_00, 5'b1_11_11, 5'b1_10_10, 5'b1_00_01, 5'b1_10_00,
    5'b1_11_11, 5'b1_00_01
  };

  task automatic chk(input logic got, input logic exp, input string req);
    checks++;
    if (got !== exp) begin
      fails++;
      $display("FAIL %s: got %b expected %b at %0t", req, got, exp, $time);
    end
  endtask

  task automatic chk_int(input int got, input int exp, input string req);
    checks++;
    if (got != exp) begin
      fails++;
      $display("FAIL %s: got %0d expected %0d", req, got, exp);
    end
  endtask

  task automatic clear_flag();
    iclr = 1'b1;
    @(negedge clk);
    iclr = 1'b0;
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    checks++;
    fails++;
    $display("FAIL watchdog: got timeout expected completion");
    finish_run();
  end

  initial begin
    repeat (3) @(negedge clk);
    // R1: reset values
    chk(vbus, 1'b0, "R1 vbus");
    chk(flag, 1'b0, "R1 flag");
    chk(irq, 1'b0, "R1 irq");
    chk(pad, 1'b0, "R1 pad");
    rst_n = 1'b1;
    @(negedge clk);

    // R2 R3 R4 R5: voltage ramps in both modes
    foreach (VEC[i]) begin
      host = VEC[i][4];
      sess = VEC[i][3];
      full = VEC[i][2];
      repeat (3) @(negedge clk);
      chk(vbus, VEC[i][1], $sformatf("R2/R3/R4 vbus vector %0d", i));
      chk(flag, VEC[i][0], $sformatf("R5 flag vector %0d", i));
      if (flag) raised++;
      clear_flag();
    end
    chk_int(raised, 6, "R5 flag count");

    // R6: set pulse, clear pulse, set with clear
    iset = 1'b1; @(negedge clk); iset = 1'b0;
    chk(flag, 1'b1, "R6 set");
    clear_flag();
    chk(flag, 1'b0, "R6 clear");
    iset = 1'b1; iclr = 1'b1; @(negedge clk); iset = 1'b0; iclr = 1'b0;
    chk(flag, 1'b1, "R6 set beats clear");

    // R7: mask
    ien = 1'b0; #1;
    chk(irq, 1'b0, "R7 masked");
    ien = 1'b1; #1;
    chk(irq, 1'b1, "R7 enabled");
    clear_flag(); #1;
    chk(irq, 1'b0, "R7 flag low");

    // R6: transition and clear in the same cycle (device mode, vbus 0)
    host = 1'b0; sess = 1'b1;
    repeat (2) @(negedge clk);
    iclr = 1'b1;
    @(negedge clk);
    chk(vbus, 1'b1, "R6 collision vbus");
    chk(flag, 1'b1, "R6 transition beats clear");
    iclr = 1'b0;
    clear_flag();

    // R8: controller disabled and detached, still tracks
    en = 1'b0; det = 1'b1; sess = 1'b0;
    repeat (3) @(negedge clk);
    chk(vbus, 1'b0, "R8 vbus falls while disabled");
    chk(flag, 1'b1, "R8 flag while disabled");
    clear_flag();

    // R10: host holds vbus 0 in band, switch to device
    host = 1'b1; sess = 1'b1; full = 1'b0;
    repeat (3) @(negedge clk);
    chk(vbus, 1'b0, "R10 host band vbus low");
    chk(flag, 1'b0, "R10 no flag in band");
    host = 1'b0;
    @(negedge clk);
    chk(vbus, 1'b1, "R10 device re-evaluates");
    chk(flag, 1'b1, "R10 flag on switch");
    clear_flag();

    // R9: all four pad combinations
    for (int k = 0; k < 4; k++) begin
      en = k[1];
      det = k[0];
      @(negedge clk);
      chk(pad, (k == 2) ? 1'b1 : 1'b0, $sformatf("R9 pad en=%0d det=%0d", k[1], k[0]));
    end

    // R1: asynchronous reset mid-run
    en = 1'b1; det = 1'b0;
    @(negedge clk);
    iset = 1'b1; @(negedge clk); iset = 1'b0;
    rst_n = 1'b0; #1;
    chk(vbus, 1'b0, "R1 async vbus");
    chk(flag, 1'b0, "R1 async flag");
    chk(pad, 1'b0, "R1 async pad");

    finish_run();
  end

endmodule